// File: doc/BRIEF.md
# Timer Clock Select Prescaler

This block decides, once per system clock, whether an 8-bit timer should advance. It produces a strobe that is one system clock wide. A 3-bit select input picks the source of that strobe. The timer can be held, stepped on every clock, or stepped at one of four divided rates. The divided rates come from a single shared free-running prescaler. The last two choices step the timer on a chosen edge of an external pin.

The pin is brought into the clock domain through a two-flop synchronizer, followed by one more history flop for edge detection. The block observes the pad level whatever is driving it. This means a pin that the chip itself drives as an output can still step the timer under software control. A prescaler clear input restarts the divided phase. The counter that consumes the strobe, the compare logic and the register access all sit outside this block.

Top module: `tick_src_sel`

## Requirements
- R1: With `sel` = 3'b000, `tick` is 0 after every clock edge at which that code was sampled.
- R2: With `sel` = 3'b001, `tick` is 1 after every clock edge at which that code was sampled.
- R3: Let j count the clock edges since the last edge with `rst` or `psc_clr` high; that last edge has j = 0. `sel` codes 3'b010, 3'b011, 3'b100 and 3'b101 select divisors of 8, 64, 256 and 1024. With one of these codes sampled, `tick` goes to 1 at edge j exactly when j is a nonzero multiple of the divisor.
- R4: At a clock edge where `psc_clr` is high, no divided tick is produced. That edge restarts the divided phase at j = 0. `psc_clr` has no effect on codes 3'b000, 3'b001, 3'b110 or 3'b111.
- R5: With `sel` = 3'b111 (rising edge), `tick` goes to 1 at edge e exactly when the pin level sampled at edge e-2 is 1 and the level sampled at edge e-3 is 0. The delay from a pin change to the tick is therefore 2 to 3 clocks.
- R6: With `sel` = 3'b110 (falling edge), `tick` goes to 1 at edge e exactly when the pin level sampled at edge e-2 is 0 and the level sampled at edge e-3 is 1.
- R7: `sel` is sampled at the same edge that registers `tick`. A new code therefore governs the strobe from the very next edge. The strobe is a single bit, so at most one tick is produced per cycle.
- R8: While `rst` is high, `tick` is 0. Reset also clears the prescaler phase and the pin history. After reset the pin history reads as level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psc_clr | input | 1 | Synchronous prescaler phase restart |
| sel | input | 3 | Strobe source select code |
| ext_pin | input | 1 | External pin level (asynchronous) |
| tick | output | 1 | One-clock count-enable strobe |

## Verification
The edge properties compare the strobe against `ext_pin` as sampled three and four clocks earlier. Those past samples reach back into the reset window. The properties therefore assume that the pin is held low while `rst` is high, which matches the reset state of the synchronizer. The stimulus keeps `ext_pin` at 0 during every reset cycle. It changes all inputs only on the falling clock edge, so each level is sampled cleanly at the next rising edge. The divided-rate properties assume that `psc_clr` is a synchronous input. The checker keeps its own count of edges since the last clear, and the stimulus drives `psc_clr` only at the same falling-edge instants.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;
  typedef enum logic [2:0] {
    SEL_OFF      = 3'b000,
    SEL_DIRECT   = 3'b001,
    SEL_DIV_A    = 3'b010,
    SEL_DIV_B    = 3'b011,
    SEL_DIV_C    = 3'b100,
    SEL_DIV_D    = 3'b101,
    SEL_EXT_FALL = 3'b110,
    SEL_EXT_RISE = 3'b111
  } tsel_e;

  localparam int unsigned NUM_TAPS = 4;
endpackage

// File: rtl/psc_chain.sv
module psc_chain #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned NTAP  = 4,
  parameter logic [NTAP*8-1:0] TAP_BITS = {8'd10, 8'd8, 8'd6, 8'd3}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [NTAP-1:0] tap_hit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // A tap fires when its low bits are all ones, i.e. the edge that wraps them.
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int unsigned B = int'(TAP_BITS[i*8 +: 8]);
    assign tap_hit[i] = (&cnt[B-1:0]) & ~clr;
  end
endmodule

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int unsigned HW = SYNC_STAGES + 1;
  logic [HW-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HW-2:0], pin};
  end

  assign rise =  hist[SYNC_STAGES-1] & ~hist[SYNC_STAGES];
  assign fall = ~hist[SYNC_STAGES-1] &  hist[SYNC_STAGES];
endmodule

// File: rtl/tick_mux.sv
module tick_mux
  import tick_sel_pkg::*;
#(
  parameter int unsigned NTAP = NUM_TAPS
) (
  input  logic [2:0]      sel,
  input  logic [NTAP-1:0] tap_hit,
  input  logic            rise,
  input  logic            fall,
  output logic            tick_d
);
  always_comb begin
    unique case (tsel_e'(sel))
      SEL_OFF:      tick_d = 1'b0;
      SEL_DIRECT:   tick_d = 1'b1;
      SEL_DIV_A:    tick_d = tap_hit[0];
      SEL_DIV_B:    tick_d = tap_hit[1];
      SEL_DIV_C:    tick_d = tap_hit[2];
      SEL_DIV_D:    tick_d = tap_hit[3];
      SEL_EXT_FALL: tick_d = fall;
      SEL_EXT_RISE: tick_d = rise;
      default:      tick_d = 1'b0;
    endcase
  end
endmodule

// File: rtl/tick_src_sel.sv
module tick_src_sel
  import tick_sel_pkg::*;
#(
  parameter int unsigned PSC_W       = 10,
  parameter logic [NUM_TAPS*8-1:0] TAP_BITS = {8'd10, 8'd8, 8'd6, 8'd3},
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       psc_clr,
  input  logic [2:0] sel,
  input  logic       ext_pin,
  output logic       tick
);
  logic [NUM_TAPS-1:0] tap_hit;
  logic                rise, fall, tick_d;

  psc_chain #(.CNT_W(PSC_W), .NTAP(NUM_TAPS), .TAP_BITS(TAP_BITS)) u_psc (
    .clk(clk), .rst(rst), .clr(psc_clr), .tap_hit(tap_hit)
  );

  pin_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(ext_pin), .rise(rise), .fall(fall)
  );

  tick_mux #(.NTAP(NUM_TAPS)) u_mux (
    .sel(sel), .tap_hit(tap_hit), .rise(rise), .fall(fall), .tick_d(tick_d)
  );

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= tick_d;
  end
endmodule

// File: rtl/tick_src_sel_chk.sv
module tick_src_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       psc_clr,
  input logic [2:0] sel,
  input logic       ext_pin,
  input logic       tick
);
  // Edges since the last reset or clear, kept independently of the design.
  logic [31:0] ph;
  always_ff @(posedge clk) begin
    if (rst || psc_clr) ph <= '0;
    else                ph <= ph + 1'b1;
  end

  function automatic logic [31:0] div_mask(input logic [2:0] s);
    case (s)
      3'b010:  return 32'd7;
      3'b011:  return 32'd63;
      3'b100:  return 32'd255;
      default: return 32'd1023;
    endcase
  endfunction

  p_off_r1: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b000) |=> !tick);

  p_direct_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b001) |=> tick);

  p_div_phase_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) inside {3'b010, 3'b011, 3'b100, 3'b101} && !$past(rst) && !$past(psc_clr))
    |-> (tick == ((ph & div_mask($past(sel))) == 32'd0)));

  p_clr_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) inside {3'b010, 3'b011, 3'b100, 3'b101} && $past(psc_clr))
    |-> !tick);

  p_ext_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == 3'b111 && !$past(rst))
    |-> (tick == ($past(ext_pin, 3) && !$past(ext_pin, 4))));

  p_ext_fall_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == 3'b110 && !$past(rst))
    |-> (tick == (!$past(ext_pin, 3) && $past(ext_pin, 4))));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> !tick);
endmodule

bind tick_src_sel tick_src_sel_chk u_chk (
  .clk(clk), .rst(rst), .psc_clr(psc_clr), .sel(sel), .ext_pin(ext_pin), .tick(tick)
);

// File: tb/tick_src_sel_tb.sv
module tick_src_sel_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       psc_clr = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       ext_pin = 1'b0;
  logic       tick;

  always #5 clk = ~clk;

  tick_src_sel u_dut (
    .clk(clk), .rst(rst), .psc_clr(psc_clr), .sel(sel), .ext_pin(ext_pin), .tick(tick)
  );

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   pcount = 0;
  logic m1 = 1'b0, m2 = 1'b0, m3 = 1'b0;
  bit   done = 1'b0;

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'b010:  return 8;
      3'b011:  return 64;
      3'b100:  return 256;
      3'b101:  return 1024;
      default: return 0;
    endcase
  endfunction

  // Drive one cycle at the falling edge; push the tick expected after the next rising edge.
  task automatic step(input logic [2:0] s, input logic p, input logic c,
                      input logic r, input string tag);
    exp_t it;
    logic e, dhit;
    int   n;
    @(negedge clk);
    rst = r; sel = s; ext_pin = p; psc_clr = c;
    n = divisor(s);
    if (r || c) begin
      pcount = 0;
      dhit = 1'b0;
    end else begin
      pcount++;
      dhit = (n > 0) && (pcount % n == 0);
    end
    case (s)
      3'b000:  e = 1'b0;
      3'b001:  e = 1'b1;
      3'b110:  e = !m2 && m3;
      3'b111:  e = m2 && !m3;
      default: e = dhit;
    endcase
    if (r) begin
      e = 1'b0;
      m1 = 1'b0; m2 = 1'b0; m3 = 1'b0;
    end else begin
      m3 = m2; m2 = m1; m1 = p;
    end
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares one scoreboard entry per cycle, away from both clock edges.
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_vec++;
        if (tick !== it.exp) begin
          n_bad++;
          $display("FAIL %s: tick=%b expected=%b at %0t", it.tag, tick, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  localparam logic [39:0] PIN_PAT = 40'b1011_0011_1000_1110_0101_1100_0110_1001_1101_0001;

  initial begin
    // R8: reset state, including a clear and a non-zero select held in reset
    for (int i = 0; i < 4; i++) step(3'b001, 1'b0, 1'b0, 1'b1, "R8");
    step(3'b010, 1'b0, 1'b1, 1'b1, "R8");
    // R2: undivided
    for (int i = 0; i < 12; i++) step(3'b001, 1'b0, 1'b0, 1'b0, "R2");
    // R1: stopped; clear and pin activity have no effect
    for (int i = 0; i < 20; i++) step(3'b000, i[1], i == 5, 1'b0, "R1");
    // R4: clear ignored by the undivided code
    for (int i = 0; i < 6; i++) step(3'b001, 1'b0, i == 2, 1'b0, "R4");
    // R3: divide by 8 from a clean phase, then mid-phase clear (R4)
    step(3'b010, 1'b0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 40; i++) step(3'b010, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 30; i++) step(3'b010, 1'b0, (i == 3) || (i == 19), 1'b0, "R4");
    // R3: divide by 64, 256, 1024
    for (int i = 0; i < 200; i++) step(3'b011, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 600; i++) step(3'b100, 1'b0, 1'b0, 1'b0, "R3");
    step(3'b101, 1'b0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 2100; i++) step(3'b101, 1'b0, 1'b0, 1'b0, "R3");
    // R5: rising edges, including single-cycle pulses
    for (int i = 0; i < 40; i++) step(3'b111, PIN_PAT[i], 1'b0, 1'b0, "R5");
    for (int i = 0; i < 4; i++) step(3'b111, 1'b0, 1'b0, 1'b0, "R5");
    // R6: falling edges; clear ignored here (R4)
    for (int i = 0; i < 40; i++) step(3'b110, PIN_PAT[39-i], i == 7, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(3'b110, 1'b1, 1'b0, 1'b0, "R6");
    // R7: select changes every few cycles take effect at the next edge
    for (int i = 0; i < 64; i++) step(3'((i / 3) % 8), PIN_PAT[i % 40], 1'b0, 1'b0, "R7");
    for (int i = 0; i < 48; i++) step(3'((i * 5) % 8), i[0], 1'b0, 1'b0, "R7");
    // R8: reset again in the middle of activity, pin held low
    for (int i = 0; i < 4; i++) step(3'b111, 1'b0, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 20; i++) step(3'b010, PIN_PAT[i], 1'b0, 1'b0, "R8");
    step(3'b000, 1'b0, 1'b0, 1'b0, "R1");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule